// File: doc/BRIEF.md
# Raster Timing Generator with Video-Transfer Arbiter

This block drives a non-interlaced greyscale raster from a 12 MHz pixel clock and shares one dual-port video DRAM between a processor and the display. Each line has 768 pixel clocks, which gives 64 µs. The first 512 clocks of a line carry pixels and the other 256 form the horizontal blanking interval. A frame has 320 lines, of which 256 are visible. The block produces horizontal and vertical blanking and sync. It also registers the pixel byte coming from the DRAM serial port, and it forces that byte to black whenever the beam is blanked.

On the last visible clock of each visible line, the block requests a row-to-serial-register transfer that loads the next line. A small arbiter grants the memory either to this transfer or to a pending processor access. Neither party is ever cut short: a transfer waits for a running processor cycle, and a processor access waits for a running transfer. Both kinds of cycle come from one 8-step one-hot shift register. That sequencer emits the row strobe, the column strobes for each byte lane, the transfer enable, the write strobe and the row/column address phase. The processor sees a one-clock acknowledge once its strobes have been released.

Top module: `rasterXferArb`

## Requirements
- R1: The horizontal position runs 0..767 and wraps, and the line count advances on each wrap. `hBlank` is high exactly while the position is 512 or more.
- R2: `hSync` is high for HSYNC_WIDTH clocks (default 64), starting HSYNC_START clocks (default 32) after horizontal blanking begins, so at positions 544..607 by default.
- R3: A frame is 320 lines and every frame repeats identically. `vBlank` is high exactly on lines 256..319.
- R4: `vSync` is high on exactly two whole lines, 288 and 289, which are the lines that begin 32 lines after the last visible line ends.
- R5: `pixOut` is a register. After a clock edge at which the position was visible on both axes, it holds the `pixIn` value sampled at that edge; otherwise it holds zero.
- R6: The line-end event is the clock whose position is 511 on a visible line. `xferReq` is high during that clock and stays high until the clock on which its transfer is granted. From the following clock, `lineAddr` shows the next line number, wrapping 255 to 0.
- R7: A transfer lasts 8 clocks, numbered steps 0..7. `xferEnN` is low in steps 0..3 and `rasN` is low in steps 1..6. Both `casUpN` and `casLoN` are low in steps 4..5, and `weN` stays high. `dramAddr` is the line number in steps 0..2 and zero in steps 3..6.
- R8: A processor cycle lasts 8 steps. `rasN` is low in steps 1..6. `dramAddr` is `cpuAddr[15:8]` in steps 0..2 and `cpuAddr[7:0]` in steps 3..6, captured at grant. `casUpN` is low in steps 4..5 only if `cpuUds` was set, and `casLoN` likewise only if `cpuLds` was set. `weN` is low in steps 2..5 only for a write (`cpuWe`=1). `xferEnN` stays high.
- R9: `cpuAck` is a single-clock pulse in step 7 of a processor cycle, after `rasN` has returned high.
- R10: A started cycle always runs all 8 steps. After step 7 there is at least one clock with every strobe inactive before the next cycle starts.
- R11: If the memory is idle and the line-end event coincides with a sampled `cpuReq`, the transfer starts first. A processor request is acknowledged no later than 17 clocks after it is first sampled.
- R12: `xferReq` is never high for more than 9 consecutive clocks.
- R13: While `rstN` is low, the position is 0/0, all active-low strobes are high, and `cpuAck`, `xferReq`, `lineAddr` and `pixOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor memory request, held until acknowledge |
| cpuWe | input | 1 | Request is a write |
| cpuUds | input | 1 | Upper byte lane selected |
| cpuLds | input | 1 | Lower byte lane selected |
| cpuAddr | input | 2*ROW_W | Word address, row in the upper half |
| pixIn | input | PIX_W | Pixel byte from the DRAM serial port |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| lineAddr | output | clog2(V_ACTIVE) | Line number loaded by the pending or latest transfer |
| xferReq | output | 1 | Transfer requested and not yet granted |
| dramAddr | output | ROW_W | Multiplexed DRAM address |
| rasN | output | 1 | Row strobe, active low |
| casUpN | output | 1 | Upper-lane column strobe, active low |
| casLoN | output | 1 | Lower-lane column strobe, active low |
| xferEnN | output | 1 | Transfer enable, active low |
| weN | output | 1 | Write strobe, active low |
| cpuAck | output | 1 | Processor cycle complete |
| pixOut | output | PIX_W | Registered pixel, black while blanked |

## Verification
A processor request and the line-end transfer request can land on the same clock. That collision is the case the arbiter exists for. The bench provokes it by raising `cpuReq` on the half-cycle just before the last visible clock while the memory is idle. On other lines a random request arrives one or more clocks earlier, so the transfer has to wait behind a processor cycle instead. A bench model of the grant order predicts every strobe and address step, and two run-length counters check the waiting bounds of 17 and 9 clocks. The bench uses a shrunken raster so that many frames and collisions fit into a short run.

// File: rtl/rasterPkg.sv
package rasterPkg;
  // Sequencer length and step windows (inclusive)
  localparam int SEQ_LEN   = 8;
  localparam int XEN_LAST  = 3;
  localparam int RAS_FIRST = 1;
  localparam int RAS_LAST  = 6;
  localparam int COL_FIRST = 3;
  localparam int CAS_FIRST = 4;
  localparam int CAS_LAST  = 5;
  localparam int WE_FIRST  = 2;
  localparam int WE_LAST   = 5;

  typedef enum logic {OWN_CPU = 1'b0, OWN_VID = 1'b1} memOwner_t;

  typedef struct packed {
    logic rasN;
    logic casUpN;
    logic casLoN;
    logic xferEnN;
    logic weN;
    logic colPhase;
    logic srcVideo;
    logic latchCpu;
    logic latchLine;
    logic blankNow;
  } memStrobes_t;
endpackage

// File: rtl/rasterTiming.sv
module rasterTiming #(
  parameter int H_ACTIVE    = 512,
  parameter int H_TOTAL     = 768,
  parameter int V_ACTIVE    = 256,
  parameter int V_TOTAL     = 320,
  parameter int VSYNC_GAP   = 32,
  parameter int VSYNC_LINES = 2,
  parameter int HSYNC_START = 32,
  parameter int HSYNC_WIDTH = 64,
  parameter int LINE_W      = $clog2(V_ACTIVE)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              hBlank,
  output logic              vBlank,
  output logic              hSync,
  output logic              vSync,
  output logic              lineEnd,
  output logic [LINE_W-1:0] nextLine
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT    = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_ENDACT = HW'(H_ACTIVE - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT    = VW'(V_ACTIVE);
  localparam logic [VW-1:0] V_ENDACT = VW'(V_ACTIVE - 1);
  localparam logic [HW:0]   HS_ON    = (HW+1)'(H_ACTIVE + HSYNC_START);
  localparam logic [HW:0]   HS_OFF   = (HW+1)'(H_ACTIVE + HSYNC_START + HSYNC_WIDTH);
  localparam logic [VW:0]   VS_ON    = (VW+1)'(V_ACTIVE + VSYNC_GAP);
  localparam logic [VW:0]   VS_OFF   = (VW+1)'(V_ACTIVE + VSYNC_GAP + VSYNC_LINES);

  logic [HW-1:0] hCount;
  logic [VW-1:0] vCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (hCount == H_LAST) begin
      hCount <= '0;
      vCount <= (vCount == V_LAST) ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_comb begin
    hBlank   = hCount >= H_ACT;
    vBlank   = vCount >= V_ACT;
    hSync    = ({1'b0, hCount} >= HS_ON) && ({1'b0, hCount} < HS_OFF);
    vSync    = ({1'b0, vCount} >= VS_ON) && ({1'b0, vCount} < VS_OFF);
    lineEnd  = (hCount == H_ENDACT) && !vBlank;
    nextLine = (vCount == V_ENDACT) ? '0 : LINE_W'(vCount + 1'b1);
  end

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (hCount == H_LAST) |=> (hCount == '0));
  a_r2_hsync_in_blank: assert property (@(posedge clk) disable iff (!rstN)
    hSync |-> hBlank);
  a_r4_vsync_in_blank: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> vBlank);
endmodule

// File: rtl/rasterCtrl.sv
module rasterCtrl
  import rasterPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineEnd,
  input  logic        blankIn,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        cpuUds,
  input  logic        cpuLds,
  output memStrobes_t stb,
  output logic        xferReq,
  output logic        cpuAck
);
  localparam int CW = $clog2(2 * SEQ_LEN + 3);

  logic [SEQ_LEN-1:0] stepSr;
  memOwner_t          owner;
  logic               pend, capWe, capUds, capLds;
  logic               busy, vidWants, grantVid, grantCpu, isVid;

  function automatic logic inRange(input logic [SEQ_LEN-1:0] sr, input int lo, input int hi);
    logic r;
    r = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++)
      if (i >= lo && i <= hi) r = r | sr[i];
    return r;
  endfunction

  always_comb begin
    busy     = |stepSr;
    vidWants = lineEnd | pend;
    grantVid = !busy && vidWants;
    grantCpu = !busy && !vidWants && cpuReq;
    isVid    = (owner == OWN_VID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepSr <= '0;
      owner  <= OWN_VID;
      pend   <= 1'b0;
      capWe  <= 1'b0;
      capUds <= 1'b0;
      capLds <= 1'b0;
    end else begin
      if (grantVid || grantCpu) stepSr <= SEQ_LEN'(1);
      else                      stepSr <= stepSr << 1;
      if (grantVid) owner <= OWN_VID;
      if (grantCpu) begin
        owner  <= OWN_CPU;
        capWe  <= cpuWe;
        capUds <= cpuUds;
        capLds <= cpuLds;
      end
      pend <= (pend | lineEnd) & !grantVid;
    end
  end

  logic casOn;
  always_comb begin
    casOn         = inRange(stepSr, CAS_FIRST, CAS_LAST);
    stb.rasN      = !inRange(stepSr, RAS_FIRST, RAS_LAST);
    stb.colPhase  = inRange(stepSr, COL_FIRST, RAS_LAST);
    stb.casUpN    = !(casOn && (isVid || capUds));
    stb.casLoN    = !(casOn && (isVid || capLds));
    stb.xferEnN   = !(isVid && inRange(stepSr, 0, XEN_LAST));
    stb.weN       = !(!isVid && capWe && inRange(stepSr, WE_FIRST, WE_LAST));
    stb.srcVideo  = isVid;
    stb.latchCpu  = grantCpu;
    stb.latchLine = lineEnd;
    stb.blankNow  = blankIn;
    xferReq       = vidWants;
    cpuAck        = !isVid && stepSr[SEQ_LEN-1];
  end

  // Run-length counters for the waiting bounds
  logic [CW-1:0] cpuRun, reqRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRun <= '0;
      reqRun <= '0;
    end else begin
      cpuRun <= (cpuReq && !cpuAck) ? cpuRun + 1'b1 : '0;
      reqRun <= xferReq ? reqRun + 1'b1 : '0;
    end
  end

  a_r10_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stepSr));
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> !cpuAck);
  a_r9_ack_after_ras: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> (stb.rasN && $past(!stb.rasN)));
  a_r11_video_wins_tie: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && lineEnd && cpuReq) |=> (!stb.xferEnN && stb.rasN));
  a_r11_cpu_wait: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuRun <= CW'(2 * SEQ_LEN + 1)));
  a_r12_xfer_wait: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> (reqRun < CW'(SEQ_LEN + 1)));
endmodule

// File: rtl/rasterData.sv
module rasterData
  import rasterPkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int PIX_W  = 8,
  parameter int LINE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  memStrobes_t        stb,
  input  logic [2*ROW_W-1:0] cpuAddr,
  input  logic [LINE_W-1:0]  nextLine,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [ROW_W-1:0]   dramAddr,
  output logic [LINE_W-1:0]  lineAddr,
  output logic [PIX_W-1:0]   pixOut,
  output logic               rasN,
  output logic               casUpN,
  output logic               casLoN,
  output logic               xferEnN,
  output logic               weN
);
  logic [2*ROW_W-1:0] cpuAddrReg;
  logic [LINE_W-1:0]  lineReg;
  logic [PIX_W-1:0]   pixReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuAddrReg <= '0;
      lineReg    <= '0;
      pixReg     <= '0;
    end else begin
      if (stb.latchCpu)  cpuAddrReg <= cpuAddr;
      if (stb.latchLine) lineReg    <= nextLine;
      pixReg <= stb.blankNow ? '0 : pixIn;
    end
  end

  always_comb begin
    if (stb.srcVideo)
      dramAddr = stb.colPhase ? '0 : ROW_W'(lineReg);
    else
      dramAddr = stb.colPhase ? cpuAddrReg[ROW_W-1:0] : cpuAddrReg[2*ROW_W-1:ROW_W];
    lineAddr = lineReg;
    pixOut   = pixReg;
    rasN     = stb.rasN;
    casUpN   = stb.casUpN;
    casLoN   = stb.casLoN;
    xferEnN  = stb.xferEnN;
    weN      = stb.weN;
  end

  a_r5_black_level: assert property (@(posedge clk) disable iff (!rstN)
    stb.blankNow |=> (pixOut == '0));
  a_r6_line_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchLine |=> $stable(lineAddr));
endmodule

// File: rtl/rasterXferArb.sv
module rasterXferArb
  import rasterPkg::*;
#(
  parameter int H_ACTIVE    = 512,
  parameter int H_TOTAL     = 768,
  parameter int V_ACTIVE    = 256,
  parameter int V_TOTAL     = 320,
  parameter int VSYNC_GAP   = 32,
  parameter int VSYNC_LINES = 2,
  parameter int HSYNC_START = 32,
  parameter int HSYNC_WIDTH = 64,
  parameter int ROW_W       = 8,
  parameter int PIX_W       = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic                         cpuUds,
  input  logic                         cpuLds,
  input  logic [2*ROW_W-1:0]           cpuAddr,
  input  logic [PIX_W-1:0]             pixIn,
  output logic                         hBlank,
  output logic                         vBlank,
  output logic                         hSync,
  output logic                         vSync,
  output logic [$clog2(V_ACTIVE)-1:0]  lineAddr,
  output logic                         xferReq,
  output logic [ROW_W-1:0]             dramAddr,
  output logic                         rasN,
  output logic                         casUpN,
  output logic                         casLoN,
  output logic                         xferEnN,
  output logic                         weN,
  output logic                         cpuAck,
  output logic [PIX_W-1:0]             pixOut
);
  localparam int LINE_W = $clog2(V_ACTIVE);

  logic              lineEnd;
  logic [LINE_W-1:0] nextLine;
  memStrobes_t       stb;

  rasterTiming #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
    .VSYNC_GAP(VSYNC_GAP), .VSYNC_LINES(VSYNC_LINES),
    .HSYNC_START(HSYNC_START), .HSYNC_WIDTH(HSYNC_WIDTH), .LINE_W(LINE_W)
  ) u_timing (
    .clk(clk), .rstN(rstN), .hBlank(hBlank), .vBlank(vBlank), .hSync(hSync),
    .vSync(vSync), .lineEnd(lineEnd), .nextLine(nextLine)
  );

  rasterCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineEnd(lineEnd), .blankIn(hBlank | vBlank),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuUds(cpuUds), .cpuLds(cpuLds),
    .stb(stb), .xferReq(xferReq), .cpuAck(cpuAck)
  );

  rasterData #(.ROW_W(ROW_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuAddr(cpuAddr), .nextLine(nextLine),
    .pixIn(pixIn), .dramAddr(dramAddr), .lineAddr(lineAddr), .pixOut(pixOut),
    .rasN(rasN), .casUpN(casUpN), .casLoN(casLoN), .xferEnN(xferEnN), .weN(weN)
  );
endmodule

// File: tb/rasterXferArb_bench.sv
module rasterXferArb_bench;
  localparam int BH_ACT = 64, BH_TOT = 96, BHS_START = 8, BHS_W = 16;
  localparam int BV_ACT = 8, BV_TOT = 16, BV_GAP = 4, BV_LINES = 2;
  localparam int ROW_W = 8, PIX_W = 8, LW = $clog2(BV_ACT), SEQ = 8;
  localparam int RUN = 12000;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic cpuReq = 1'b0, cpuWe = 1'b0, cpuUds = 1'b0, cpuLds = 1'b0;
  logic [2*ROW_W-1:0] cpuAddr = '0;
  logic [PIX_W-1:0]   pixIn = '0;
  logic hBlank, vBlank, hSync, vSync, xferReq, rasN, casUpN, casLoN, xferEnN, weN, cpuAck;
  logic [LW-1:0]    lineAddr;
  logic [ROW_W-1:0] dramAddr;
  logic [PIX_W-1:0] pixOut;

  rasterXferArb #(
    .H_ACTIVE(BH_ACT), .H_TOTAL(BH_TOT), .V_ACTIVE(BV_ACT), .V_TOTAL(BV_TOT),
    .VSYNC_GAP(BV_GAP), .VSYNC_LINES(BV_LINES), .HSYNC_START(BHS_START),
    .HSYNC_WIDTH(BHS_W), .ROW_W(ROW_W), .PIX_W(PIX_W)
  ) u_rasterXferArb (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuUds(cpuUds),
    .cpuLds(cpuLds), .cpuAddr(cpuAddr), .pixIn(pixIn), .hBlank(hBlank),
    .vBlank(vBlank), .hSync(hSync), .vSync(vSync), .lineAddr(lineAddr),
    .xferReq(xferReq), .dramAddr(dramAddr), .rasN(rasN), .casUpN(casUpN),
    .casLoN(casLoN), .xferEnN(xferEnN), .weN(weN), .cpuAck(cpuAck), .pixOut(pixOut)
  );

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected step windows from the requirements
  function automatic bit fRasOn(int s); return s >= 1 && s <= 6; endfunction
  function automatic bit fCasOn(int s); return s >= 4 && s <= 5; endfunction
  function automatic bit fXenOn(int s); return s >= 0 && s <= 3; endfunction
  function automatic bit fWeOn(int s);  return s >= 2 && s <= 5; endfunction
  function automatic bit fColOn(int s); return s >= 3 && s <= 6; endfunction
  function automatic bit fLineEnd(int h, int v); return h == BH_ACT - 1 && v < BV_ACT; endfunction

  // Reference model state, advanced on each rising edge
  int mh = 0, mv = 0, mStep = -1, mLine = 0, mPix = 0, mAddr = 0;
  bit mPend = 0, mOwnVid = 1, mWe = 0, mUds = 0, mLds = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mh = 0; mv = 0; mStep = -1; mLine = 0; mPix = 0; mPend = 0; mOwnVid = 1;
    end else begin
      bit ev, vidW, busy, gv, gc;
      cyc++;
      ev   = fLineEnd(mh, mv);
      vidW = ev || mPend;
      busy = mStep >= 0;
      gv   = !busy && vidW;
      gc   = !busy && !vidW && cpuReq;
      mPix = (mh < BH_ACT && mv < BV_ACT) ? int'(pixIn) : 0;
      if (ev) mLine = (mv == BV_ACT - 1) ? 0 : mv + 1;
      if (gv || gc) mStep = 0;
      else if (busy) mStep = (mStep == SEQ - 1) ? -1 : mStep + 1;
      if (gv) mOwnVid = 1;
      if (gc) begin
        mOwnVid = 0; mAddr = int'(cpuAddr); mWe = cpuWe; mUds = cpuUds; mLds = cpuLds;
      end
      mPend = (mPend || ev) && !gv;
      if (mh == BH_TOT - 1) begin
        mh = 0;
        mv = (mv == BV_TOT - 1) ? 0 : mv + 1;
      end else mh = mh + 1;
    end
  end

  bit seeded = 0, collideChk = 0;
  int cpuWait = 0, xReqRun = 0;

  always @(negedge clk) begin
    if (!seeded) begin
      seeded = 1;
      void'($urandom(32'h1d5e));
    end
    if (!rstN) begin
      chk(rasN && casUpN && casLoN && xferEnN && weN, "R13 strobes idle in reset",
          {rasN, casUpN, casLoN, xferEnN, weN}, 5'b11111);
      chk(!cpuAck && !xferReq, "R13 ack/req low in reset", {cpuAck, xferReq}, 0);
      chk(lineAddr == 0 && pixOut == 0 && !hBlank && !vBlank, "R13 reset position/data",
          {lineAddr, pixOut}, 0);
    end else begin
      bit ev;
      int s;
      ev = fLineEnd(mh, mv);
      s  = mStep;
      chk(hBlank == (mh >= BH_ACT), "R1 hBlank", hBlank, mh >= BH_ACT);
      chk(hSync == (mh >= BH_ACT + BHS_START && mh < BH_ACT + BHS_START + BHS_W),
          "R2 hSync", hSync, mh >= BH_ACT + BHS_START && mh < BH_ACT + BHS_START + BHS_W);
      chk(vBlank == (mv >= BV_ACT), "R3 vBlank", vBlank, mv >= BV_ACT);
      chk(vSync == (mv >= BV_ACT + BV_GAP && mv < BV_ACT + BV_GAP + BV_LINES),
          "R4 vSync", vSync, mv >= BV_ACT + BV_GAP && mv < BV_ACT + BV_GAP + BV_LINES);
      chk(int'(pixOut) == mPix, "R5 pixOut", pixOut, mPix);
      chk(xferReq == (ev || mPend), "R6 xferReq", xferReq, ev || mPend);
      chk(int'(lineAddr) == mLine, "R6 lineAddr", lineAddr, mLine);
      if (s < 0) begin
        chk(rasN && casUpN && casLoN && xferEnN && weN && !cpuAck, "R10 idle strobes",
            {rasN, casUpN, casLoN, xferEnN, weN, cpuAck}, 6'b111110);
      end else if (mOwnVid) begin
        chk(rasN == !fRasOn(s), "R7 rasN", rasN, !fRasOn(s));
        chk(casUpN == !fCasOn(s) && casLoN == !fCasOn(s), "R7 cas", {casUpN, casLoN},
            {!fCasOn(s), !fCasOn(s)});
        chk(xferEnN == !fXenOn(s) && weN && !cpuAck, "R7 xferEnN/weN", {xferEnN, weN, cpuAck},
            {!fXenOn(s), 2'b10});
        if (s <= 6)
          chk(int'(dramAddr) == (fColOn(s) ? 0 : mLine), "R7 dramAddr", dramAddr,
              fColOn(s) ? 0 : mLine);
      end else begin
        chk(rasN == !fRasOn(s), "R8 rasN", rasN, !fRasOn(s));
        chk(casUpN == !(fCasOn(s) && mUds), "R8 casUpN", casUpN, !(fCasOn(s) && mUds));
        chk(casLoN == !(fCasOn(s) && mLds), "R8 casLoN", casLoN, !(fCasOn(s) && mLds));
        chk(weN == !(fWeOn(s) && mWe) && xferEnN, "R8 weN/xferEnN", {weN, xferEnN},
            {!(fWeOn(s) && mWe), 1'b1});
        if (s <= 6)
          chk(int'(dramAddr) == (fColOn(s) ? (mAddr & 255) : (mAddr >> 8)), "R8 dramAddr",
              dramAddr, fColOn(s) ? (mAddr & 255) : (mAddr >> 8));
        chk(cpuAck == (s == SEQ - 1), "R9 cpuAck", cpuAck, s == SEQ - 1);
      end
      if (collideChk) begin
        chk(!xferEnN && rasN, "R11 transfer wins tie", {xferEnN, rasN}, 2'b01);
        collideChk = 0;
      end
      if (xferReq) xReqRun++;
      else if (xReqRun > 0) begin
        chk(xReqRun <= SEQ + 1, "R12 xferReq length", xReqRun, SEQ + 1);
        xReqRun = 0;
      end
      // Processor driver
      if (cpuReq && cpuAck) begin
        chk(cpuWait <= 2 * SEQ, "R11 cpu wait", cpuWait, 2 * SEQ);
        cpuReq = 1'b0;
        cpuWait = 0;
      end else if (cpuReq) begin
        cpuWait++;
      end else if (cyc < RUN) begin
        bit go;
        go = 0;
        if (ev && s < 0 && ($urandom % 2 == 0)) begin
          go = 1;
          collideChk = 1;
        end else if ($urandom % 12 == 0) go = 1;
        if (go) begin
          cpuReq  = 1'b1;
          cpuAddr = (2*ROW_W)'($urandom);
          cpuWe   = 1'($urandom % 2);
          {cpuUds, cpuLds} = 2'(1 + $urandom % 3);
        end
      end
      pixIn = PIX_W'($urandom);
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (RUN + 100) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, RUN);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule